// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block is the state machine that carries a small processor system between its full-speed run state and a ladder of power-saving states. It takes software configuration as level inputs: a low-power-run request, a deep-sleep select, a three-bit depth select, a regulator choice for light sleep, a retention bit and a sleep-on-exit bit. The core supplies wait-for-interrupt and wait-for-event strobes and a handler-return pulse. Interrupt, event and wake-pin class inputs bring the system back. From the current state the block decodes the main and low-power regulator enables, the core and peripheral clock enables, permission for a fast system clock, SRAM retention, the two slow oscillator enables, a low-power-regulator status flag and a system reset request.

Regulator start-up is modelled by a settle counter. It runs while the block enters or leaves low-power run and while it returns from a stop level. It advances only in cycles where the regulator-ready input is high. The settle lengths are parameters. The stop-1 and stop-2 length is meant to be longer than the stop-0 length.

Top module: `lpm_seq`

## Requirements
- R1: While rst_ni is low and right after it rises, state_o is 0 (run), the main regulator and both clocks are on, fast_clk_ok_o is 1, the low-power regulator is off, and reglp_flag_o and sys_rst_req_o are 0.
- R2: In run, lpr_i high moves to state 1 (entering low-power run, both regulators on), which lasts LPR_SETTLE+1 cycles with reg_rdy_i high. Cycles with reg_rdy_i low add to that count. The block then reaches state 2 (low-power run: main regulator off, low-power regulator on, reglp_flag_o high).
- R3: In state 2, lpr_i low moves to state 3 (leaving: main regulator on, flag still high) for LPR_SETTLE+1 ready cycles and then to run. The flag falls in the same cycle that fast_clk_ok_o rises, and the two are never high together.
- R4: With deep_sleep_i low, a wait strobe in run with lp_reg_sel_i low enters state 4 (sleep: core clock off, peripheral clock on, main regulator on). A wait strobe in state 2 with lp_reg_sel_i high enters state 5 (low-power sleep, main regulator off).
- R5: A light-sleep strobe whose regulator choice disagrees with the present run state passes through the matching settle state first. From run with lp_reg_sel_i high the path is state 1 and then state 5. From state 2 with lp_reg_sel_i low the path is state 3 and then state 4.
- R6: A wait entered with wfi_i (or with both strobes) is left on irq_i or evt_i. One entered with wfe_i alone is left only on evt_i. Sleep returns to run and low-power sleep returns to state 2 on the next edge.
- R7: With deep_sleep_i high, a wait strobe selects a level by mode_sel_i. 0 gives stop 0 (state 6, main regulator on). 1 gives stop 1 (state 7) and 2 gives stop 2 (state 8); both keep only the low-power regulator on. 3 gives standby: state 9 with retain_i high (low-power regulator on, retain_en_o high) or state 10 with retain_i low (both regulators off). 4 to 7 give shutdown (state 11: both regulators and slow_int_clk_en_o off). All clocks are off in these states, and slow_ext_clk_en_o is always high.
- R8: A stop-0 or stop-1 wake (rule of R6) enters state 12 (return settle, clocks off) for STOP0_SETTLE+1 or STOP1_SETTLE+1 ready cycles. It then goes to state 2 if lpr_i was high at the wake edge, otherwise to run; main_reg_on_o in state 12 is low only when heading to state 2.
- R9: Stop 2 ignores irq_i and evt_i and is left only on lp_wake_i. It then spends STOP1_SETTLE+1 cycles in state 12 and always returns to run, whatever lpr_i is.
- R10: States 9, 10 and 11 ignore irq_i and evt_i. lp_wake_i moves them to state 13, where sys_rst_req_o is high for one cycle; the next state is run.
- R11: With sleep_on_exit_i high, handler_ret_i in run enters sleep and in state 2 enters low-power sleep, both with the wait-for-interrupt wake rule.
- R12: In run and in state 2, a cycle with irq_i, evt_i or lp_wake_i high blocks any wait strobe and handler-return entry in that cycle. A clear lpr_i in state 2 and a set lpr_i in run are still acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| lpr_i | input | 1 | low-power run request |
| deep_sleep_i | input | 1 | wait strobes go to a stop/standby level |
| mode_sel_i | input | 3 | deep level select (R7) |
| lp_reg_sel_i | input | 1 | light sleep on the low-power regulator |
| retain_i | input | 1 | standby keeps SRAM retention |
| sleep_on_exit_i | input | 1 | re-sleep on handler return |
| wfi_i | input | 1 | wait-for-interrupt strobe |
| wfe_i | input | 1 | wait-for-event strobe |
| handler_ret_i | input | 1 | handler-to-thread return pulse |
| irq_i | input | 1 | enabled interrupt pending |
| evt_i | input | 1 | wake event |
| lp_wake_i | input | 1 | wake pin / always-on wake source |
| reg_rdy_i | input | 1 | regulator ready, gates the settle count |
| main_reg_on_o | output | 1 | main regulator enable |
| lp_reg_on_o | output | 1 | low-power regulator enable |
| core_clk_en_o | output | 1 | core clock enable |
| periph_clk_en_o | output | 1 | peripheral clock enable |
| fast_clk_ok_o | output | 1 | system clock may exceed the low-power limit |
| retain_en_o | output | 1 | SRAM retention supply |
| slow_int_clk_en_o | output | 1 | internal slow oscillator enable |
| slow_ext_clk_en_o | output | 1 | external slow oscillator enable |
| reglp_flag_o | output | 1 | low-power regulator status flag |
| sys_rst_req_o | output | 1 | system reset request |
| state_o | output | 4 | current state code (codes in R1 to R10) |

## Verification
The properties assume that wait strobes and handler-return are single-cycle pulses. They also assume that wake inputs are levels sampled at the clock edge, with no setup from the sequencer expected. The property on wake priority assumes lpr_i is low in that cycle, because a set lpr_i in run is meant to win over a wake. The stimulus changes inputs only between edges, pulses each strobe for exactly one edge and, before any return to run, clears lpr_i unless the case under test needs it set.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic [3:0] {
    ST_RUN      = 4'd0,
    ST_LPR_ENT  = 4'd1,
    ST_LPR      = 4'd2,
    ST_LPR_EXIT = 4'd3,
    ST_SLEEP    = 4'd4,
    ST_LPSLEEP  = 4'd5,
    ST_STOP0    = 4'd6,
    ST_STOP1    = 4'd7,
    ST_STOP2    = 4'd8,
    ST_STBY_RET = 4'd9,
    ST_STBY     = 4'd10,
    ST_SHDN     = 4'd11,
    ST_WAKE     = 4'd12,
    ST_RSTREQ   = 4'd13
  } lpm_state_e;

  localparam logic [2:0] MODE_STOP0 = 3'd0;
  localparam logic [2:0] MODE_STOP1 = 3'd1;
  localparam logic [2:0] MODE_STOP2 = 3'd2;
  localparam logic [2:0] MODE_STBY  = 3'd3;

  typedef struct packed {
    logic main_reg;
    logic lp_reg;
    logic core_clk;
    logic periph_clk;
    logic fast_ok;
    logic flag;
    logic retain;
    logic slow_int;
    logic slow_ext;
    logic rst_req;
  } lpm_out_t;
endpackage

// File: rtl/lpm_wake_sel.sv
module lpm_wake_sel
  import lpm_pkg::*;
(
  input  lpm_state_e state_i,
  input  logic       wfe_mode_i,
  input  logic       irq_i,
  input  logic       evt_i,
  input  logic       lp_wake_i,
  output logic       wake_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic core_wake;
  assign core_wake = wfe_mode_i ? evt_i : (irq_i | evt_i);

  always_comb begin
    unique case (state_i)
      ST_SLEEP, ST_LPSLEEP, ST_STOP0, ST_STOP1:   wake_o = core_wake;
      ST_STOP2, ST_STBY_RET, ST_STBY, ST_SHDN:   wake_o = lp_wake_i;
      default:                                   wake_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/lpm_settle_cnt.sv
module lpm_settle_cnt #(
  parameter int unsigned CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          tick_i,
  output logic          done_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= load_val_i;
    else if (tick_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/lpm_out_dec.sv
module lpm_out_dec
  import lpm_pkg::*;
(
  input  lpm_state_e state_i,
  input  logic       tgt_lp_i,
  output lpm_out_t   out_o
);
  timeunit 1ns;
  timeprecision 1ps;

  always_comb begin
    out_o          = '0;
    out_o.slow_int = 1'b1;
    out_o.slow_ext = 1'b1;
    unique case (state_i)
      ST_RUN: begin
        out_o.main_reg = 1'b1; out_o.core_clk = 1'b1;
        out_o.periph_clk = 1'b1; out_o.fast_ok = 1'b1;
      end
      ST_LPR_ENT: begin
        out_o.main_reg = 1'b1; out_o.lp_reg = 1'b1;
        out_o.core_clk = 1'b1; out_o.periph_clk = 1'b1;
      end
      ST_LPR: begin
        out_o.lp_reg = 1'b1; out_o.core_clk = 1'b1;
        out_o.periph_clk = 1'b1; out_o.flag = 1'b1;
      end
      ST_LPR_EXIT: begin
        out_o.main_reg = 1'b1; out_o.lp_reg = 1'b1; out_o.core_clk = 1'b1;
        out_o.periph_clk = 1'b1; out_o.flag = 1'b1;
      end
      ST_SLEEP: begin
        out_o.main_reg = 1'b1; out_o.periph_clk = 1'b1; out_o.fast_ok = 1'b1;
      end
      ST_LPSLEEP: begin
        out_o.lp_reg = 1'b1; out_o.periph_clk = 1'b1; out_o.flag = 1'b1;
      end
      ST_STOP0:            out_o.main_reg = 1'b1;
      ST_STOP1, ST_STOP2:  out_o.lp_reg = 1'b1;
      ST_STBY_RET: begin
        out_o.lp_reg = 1'b1; out_o.retain = 1'b1;
      end
      ST_STBY: ;
      ST_SHDN:             out_o.slow_int = 1'b0;
      ST_WAKE: begin
        out_o.main_reg = ~tgt_lp_i; out_o.lp_reg = 1'b1;
      end
      ST_RSTREQ: begin
        out_o.main_reg = 1'b1; out_o.rst_req = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int unsigned LPR_SETTLE   = 3,
  parameter int unsigned STOP0_SETTLE = 2,
  parameter int unsigned STOP1_SETTLE = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lpr_i,
  input  logic       deep_sleep_i,
  input  logic [2:0] mode_sel_i,
  input  logic       lp_reg_sel_i,
  input  logic       retain_i,
  input  logic       sleep_on_exit_i,
  input  logic       wfi_i,
  input  logic       wfe_i,
  input  logic       handler_ret_i,
  input  logic       irq_i,
  input  logic       evt_i,
  input  logic       lp_wake_i,
  input  logic       reg_rdy_i,
  output logic       main_reg_on_o,
  output logic       lp_reg_on_o,
  output logic       core_clk_en_o,
  output logic       periph_clk_en_o,
  output logic       fast_clk_ok_o,
  output logic       retain_en_o,
  output logic       slow_int_clk_en_o,
  output logic       slow_ext_clk_en_o,
  output logic       reglp_flag_o,
  output logic       sys_rst_req_o,
  output logic [3:0] state_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned MAX_A  = (LPR_SETTLE > STOP0_SETTLE) ? LPR_SETTLE : STOP0_SETTLE;
  localparam int unsigned MAX_S  = (MAX_A > STOP1_SETTLE) ? MAX_A : STOP1_SETTLE;
  localparam int unsigned CW     = (MAX_S < 1) ? 1 : $clog2(MAX_S + 1);
  localparam logic [CW-1:0] LPR_N   = CW'(LPR_SETTLE);
  localparam logic [CW-1:0] STOP0_N = CW'(STOP0_SETTLE);
  localparam logic [CW-1:0] STOP1_N = CW'(STOP1_SETTLE);

  lpm_state_e    state_q, state_d, deep_tgt;
  logic          pend_q, pend_d;     // light sleep queued behind a settle
  logic          wfe_q, wfe_d;
  logic          tgt_lp_q, tgt_lp_d;
  logic          load;
  logic [CW-1:0] load_val;
  logic          settling, tick, done, leave, wake_hit;
  logic          strobe, strobe_wfe, run_wake, hret;
  lpm_out_t      outs;

  assign strobe     = wfi_i | wfe_i;
  assign strobe_wfe = wfe_i & ~wfi_i;
  assign run_wake   = irq_i | evt_i | lp_wake_i;
  assign hret       = sleep_on_exit_i & handler_ret_i;
  assign settling   = (state_q == ST_LPR_ENT) || (state_q == ST_LPR_EXIT) || (state_q == ST_WAKE);
  assign tick       = settling & reg_rdy_i;
  assign leave      = tick & done;

  always_comb begin
    unique case (mode_sel_i)
      MODE_STOP0: deep_tgt = ST_STOP0;
      MODE_STOP1: deep_tgt = ST_STOP1;
      MODE_STOP2: deep_tgt = ST_STOP2;
      MODE_STBY:  deep_tgt = retain_i ? ST_STBY_RET : ST_STBY;
      default:    deep_tgt = ST_SHDN;
    endcase
  end

  lpm_wake_sel i_wake_sel (
    .state_i    (state_q),
    .wfe_mode_i (wfe_q),
    .irq_i      (irq_i),
    .evt_i      (evt_i),
    .lp_wake_i  (lp_wake_i),
    .wake_o     (wake_hit)
  );

  lpm_settle_cnt #(.CW(CW)) i_settle (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .tick_i     (tick),
    .done_o     (done)
  );

  always_comb begin
    state_d  = state_q;
    pend_d   = pend_q;
    wfe_d    = wfe_q;
    tgt_lp_d = tgt_lp_q;
    load     = 1'b0;
    load_val = LPR_N;
    unique case (state_q)
      ST_RUN: begin
        if (lpr_i) begin
          state_d = ST_LPR_ENT; load = 1'b1; pend_d = 1'b0;
        end else if (run_wake) begin
          state_d = ST_RUN;
        end else if (strobe) begin
          wfe_d = strobe_wfe;
          if (deep_sleep_i) state_d = deep_tgt;
          else if (lp_reg_sel_i) begin
            state_d = ST_LPR_ENT; load = 1'b1; pend_d = 1'b1;
          end else state_d = ST_SLEEP;
        end else if (hret) begin
          state_d = ST_SLEEP; wfe_d = 1'b0;
        end
      end
      ST_LPR_ENT:  if (leave) begin
        state_d = pend_q ? ST_LPSLEEP : ST_LPR; pend_d = 1'b0;
      end
      ST_LPR: begin
        if (!lpr_i) begin
          state_d = ST_LPR_EXIT; load = 1'b1; pend_d = 1'b0;
        end else if (run_wake) begin
          state_d = ST_LPR;
        end else if (strobe) begin
          wfe_d = strobe_wfe;
          if (deep_sleep_i) state_d = deep_tgt;
          else if (lp_reg_sel_i) state_d = ST_LPSLEEP;
          else begin
            state_d = ST_LPR_EXIT; load = 1'b1; pend_d = 1'b1;
          end
        end else if (hret) begin
          state_d = ST_LPSLEEP; wfe_d = 1'b0;
        end
      end
      ST_LPR_EXIT: if (leave) begin
        state_d = pend_q ? ST_SLEEP : ST_RUN; pend_d = 1'b0;
      end
      ST_SLEEP:    if (wake_hit) state_d = ST_RUN;
      ST_LPSLEEP:  if (wake_hit) state_d = ST_LPR;
      ST_STOP0: if (wake_hit) begin
        state_d = ST_WAKE; load = 1'b1; load_val = STOP0_N; tgt_lp_d = lpr_i;
      end
      ST_STOP1: if (wake_hit) begin
        state_d = ST_WAKE; load = 1'b1; load_val = STOP1_N; tgt_lp_d = lpr_i;
      end
      ST_STOP2: if (wake_hit) begin
        state_d = ST_WAKE; load = 1'b1; load_val = STOP1_N; tgt_lp_d = 1'b0;
      end
      ST_STBY_RET, ST_STBY, ST_SHDN: if (wake_hit) state_d = ST_RSTREQ;
      ST_WAKE:   if (leave) state_d = tgt_lp_q ? ST_LPR : ST_RUN;
      ST_RSTREQ: state_d = ST_RUN;
      default:   state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_RUN;
      pend_q   <= 1'b0;
      wfe_q    <= 1'b0;
      tgt_lp_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      pend_q   <= pend_d;
      wfe_q    <= wfe_d;
      tgt_lp_q <= tgt_lp_d;
    end
  end

  lpm_out_dec i_out_dec (
    .state_i  (state_q),
    .tgt_lp_i (tgt_lp_q),
    .out_o    (outs)
  );

  assign main_reg_on_o     = outs.main_reg;
  assign lp_reg_on_o       = outs.lp_reg;
  assign core_clk_en_o     = outs.core_clk;
  assign periph_clk_en_o   = outs.periph_clk;
  assign fast_clk_ok_o     = outs.fast_ok;
  assign retain_en_o       = outs.retain;
  assign slow_int_clk_en_o = outs.slow_int;
  assign slow_ext_clk_en_o = outs.slow_ext;
  assign reglp_flag_o      = outs.flag;
  assign sys_rst_req_o     = outs.rst_req;
  assign state_o           = state_q;
endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk
  import lpm_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       lpr_i,
  input logic       irq_i,
  input logic       evt_i,
  input logic       lp_wake_i,
  input logic       main_reg_on_o,
  input logic       lp_reg_on_o,
  input logic       fast_clk_ok_o,
  input logic       reglp_flag_o,
  input logic       sys_rst_req_o,
  input logic [3:0] state_o
);
  timeunit 1ns;
  timeprecision 1ps;

  a_r3_fast_excl_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_clk_ok_o |-> !reglp_flag_o);

  a_r6_lpsleep_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_LPSLEEP |=> (state_o == ST_LPSLEEP || state_o == ST_LPR));

  a_r9_stop2_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_STOP2 |=> (state_o == ST_STOP2 || state_o == ST_WAKE));

  a_r8_wake_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_WAKE |=> (state_o == ST_WAKE || state_o == ST_RUN || state_o == ST_LPR));

  a_r10_rst_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_req_o) |-> ($past(state_o) == ST_STBY_RET || $past(state_o) == ST_STBY ||
                              $past(state_o) == ST_SHDN));

  a_r10_rst_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_req_o |=> (!sys_rst_req_o && state_o == ST_RUN));

  a_r12_wake_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_RUN && !lpr_i && (irq_i || evt_i || lp_wake_i)) |=> state_o == ST_RUN);

  a_r7_regs_off_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!main_reg_on_o && !lp_reg_on_o) |-> (state_o == ST_STBY || state_o == ST_SHDN));
endmodule

bind lpm_seq lpm_seq_chk i_chk (.*);

// File: tb/test_lpm_seq.sv
module test_lpm_seq;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [3:0] RUN = 0, LPE = 1, LPR = 2, LPX = 3, SLP = 4, LPS = 5, S0 = 6,
                         S1 = 7, S2 = 8, SBR = 9, SB = 10, SD = 11, WK = 12, RQ = 13;
  localparam int WD_CYC = 200000;

  typedef struct {
    logic [3:0] st;
    logic       wmain;
    string      req;
  } exp_t;

  logic clk = 0, rst_ni = 0;
  logic lpr = 0, deep = 0, lp_sel = 0, retain = 0, soe = 0;
  logic wfi = 0, wfe = 0, hret = 0, irq = 0, evt = 0, lp_wake = 0, rdy = 1;
  logic [2:0] mode = 0;
  logic main_o, lp_o, core_o, per_o, fast_o, ret_o, sint_o, sext_o, flag_o, rst_o;
  logic [3:0] state_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  lpm_seq i_lpm_seq (
    .clk_i(clk), .rst_ni(rst_ni), .lpr_i(lpr), .deep_sleep_i(deep), .mode_sel_i(mode),
    .lp_reg_sel_i(lp_sel), .retain_i(retain), .sleep_on_exit_i(soe), .wfi_i(wfi),
    .wfe_i(wfe), .handler_ret_i(hret), .irq_i(irq), .evt_i(evt), .lp_wake_i(lp_wake),
    .reg_rdy_i(rdy), .main_reg_on_o(main_o), .lp_reg_on_o(lp_o), .core_clk_en_o(core_o),
    .periph_clk_en_o(per_o), .fast_clk_ok_o(fast_o), .retain_en_o(ret_o),
    .slow_int_clk_en_o(sint_o), .slow_ext_clk_en_o(sext_o), .reglp_flag_o(flag_o),
    .sys_rst_req_o(rst_o), .state_o(state_o));

  // {main, lp, core, periph, fast, flag, retain, slow_int, slow_ext, rst}, per R1-R10 text
  function automatic logic [9:0] exp_outs(logic [3:0] st, logic wm);
    case (st)
      RUN: return 10'b1_0_1_1_1_0_0_1_1_0;
      LPE: return 10'b1_1_1_1_0_0_0_1_1_0;
      LPR: return 10'b0_1_1_1_0_1_0_1_1_0;
      LPX: return 10'b1_1_1_1_0_1_0_1_1_0;
      SLP: return 10'b1_0_0_1_1_0_0_1_1_0;
      LPS: return 10'b0_1_0_1_0_1_0_1_1_0;
      S0:  return 10'b1_0_0_0_0_0_0_1_1_0;
      S1, S2: return 10'b0_1_0_0_0_0_0_1_1_0;
      SBR: return 10'b0_1_0_0_0_0_1_1_1_0;
      SB:  return 10'b0_0_0_0_0_0_0_1_1_0;
      SD:  return 10'b0_0_0_0_0_0_0_0_1_0;
      WK:  return {wm, 9'b1_0_0_0_0_0_1_1_0};
      default: return 10'b1_0_0_0_0_0_0_1_1_1;
    endcase
  endfunction

  // monitor: pops one expected item per clock edge that the driver announced
  always begin
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      exp_t e;
      logic [9:0] act, exp;
      e   = q.pop_front();
      act = {main_o, lp_o, core_o, per_o, fast_o, flag_o, ret_o, sint_o, sext_o, rst_o};
      exp = exp_outs(e.st, e.wmain);
      n_run++;
      if (state_o !== e.st || act !== exp) begin
        n_fail++;
        $display("FAIL %s: state %0d outs %b, expected state %0d outs %b",
                 e.req, state_o, act, e.st, exp);
      end
    end
  end

  // driver: inputs set at negedge apply to the next edge; e is the state after it
  task automatic cyc(logic [3:0] st, string req, logic wm = 1'b1);
    exp_t e;
    e.st = st; e.wmain = wm; e.req = req;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic cycn(int n, logic [3:0] st, string req, logic wm = 1'b1);
    for (int i = 0; i < n; i++) cyc(st, req, wm);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(WD_CYC * 5.0);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    cycn(2, RUN, "R1");                          // R1 during reset
    rst_ni = 1; cyc(RUN, "R1");

    wfi = 1; cyc(SLP, "R4"); wfi = 0;            // R4 light sleep from run
    cycn(2, SLP, "R4");
    irq = 1; cyc(RUN, "R6"); irq = 0;

    wfe = 1; cyc(SLP, "R6"); wfe = 0;            // R6 WFE ignores irq
    irq = 1; cyc(SLP, "R6"); irq = 0;
    evt = 1; cyc(RUN, "R6"); evt = 0;

    wfi = 1; irq = 1; cyc(RUN, "R12"); wfi = 0; irq = 0;
    soe = 1; hret = 1; evt = 1; cyc(RUN, "R12"); hret = 0; evt = 0; soe = 0;
    deep = 1; wfe = 1; lp_wake = 1; cyc(RUN, "R12"); deep = 0; wfe = 0; lp_wake = 0;

    lpr = 1; cyc(LPE, "R2");                     // R2 with ready stall
    rdy = 0; cycn(2, LPE, "R2"); rdy = 1;
    cycn(3, LPE, "R2"); cyc(LPR, "R2");

    lp_sel = 1; wfi = 1; cyc(LPS, "R4"); wfi = 0;
    cyc(LPS, "R4");
    irq = 1; cyc(LPR, "R6"); irq = 0;

    soe = 1; hret = 1; cyc(LPS, "R11"); hret = 0; // R11 in low-power run
    cyc(LPS, "R11");
    evt = 1; cyc(LPR, "R11"); evt = 0; soe = 0;

    lp_sel = 0; wfi = 1; cyc(LPX, "R5"); wfi = 0; lpr = 0;
    cycn(3, LPX, "R5"); cyc(SLP, "R5");
    irq = 1; cyc(RUN, "R5"); irq = 0;

    lpr = 1; cycn(4, LPE, "R3"); cyc(LPR, "R3");  // R3 exit handshake
    lpr = 0; cycn(4, LPX, "R3"); cyc(RUN, "R3");

    lp_sel = 1; wfi = 1; cyc(LPE, "R5"); wfi = 0;
    cycn(3, LPE, "R5"); cyc(LPS, "R5");
    irq = 1; cyc(LPR, "R5"); irq = 0; lp_sel = 0;
    cycn(4, LPX, "R5"); cyc(RUN, "R5");

    deep = 1; mode = 0; wfi = 1; cyc(S0, "R7"); wfi = 0;
    cyc(S0, "R7");
    irq = 1; cyc(WK, "R8"); irq = 0;
    cycn(2, WK, "R8"); cyc(RUN, "R8");

    mode = 1; wfe = 1; cyc(S1, "R7"); wfe = 0;
    irq = 1; cyc(S1, "R6"); irq = 0;
    evt = 1; lpr = 1; cyc(WK, "R8", 1'b0); evt = 0;
    cycn(6, WK, "R8", 1'b0); cyc(LPR, "R8");
    lpr = 0; cycn(4, LPX, "R8"); cyc(RUN, "R8");

    mode = 2; wfi = 1; cyc(S2, "R7"); wfi = 0;
    irq = 1; evt = 1; cyc(S2, "R9"); irq = 0; evt = 0;
    lp_wake = 1; lpr = 1; cyc(WK, "R9"); lp_wake = 0;
    cycn(6, WK, "R9"); cyc(RUN, "R9"); lpr = 0;
    cyc(RUN, "R9");

    mode = 3; retain = 1; wfi = 1; cyc(SBR, "R7"); wfi = 0;
    irq = 1; evt = 1; cyc(SBR, "R10"); irq = 0; evt = 0;
    lp_wake = 1; cyc(RQ, "R10"); lp_wake = 0;
    cyc(RUN, "R10");

    retain = 0; wfe = 1; cyc(SB, "R7"); wfe = 0;
    lp_wake = 1; cyc(RQ, "R10"); lp_wake = 0;
    cyc(RUN, "R10");

    mode = 5; wfi = 1; cyc(SD, "R7"); wfi = 0;
    cyc(SD, "R7");
    lp_wake = 1; cyc(RQ, "R10"); lp_wake = 0;
    cyc(RUN, "R10"); deep = 0;

    soe = 1; hret = 1; cyc(SLP, "R11"); hret = 0; // R11 in run
    evt = 1; cyc(RUN, "R11"); evt = 0; soe = 0;

    cycn(2, RUN, "R1");
    done = 1;
    finish_run();
  end
endmodule